// File: doc/BRIEF.md
# Narrow-to-wide stream packer

This block sits between a streaming producer that emits narrow words and a consumer that takes wide words. It accepts words through a valid/ready handshake and collects a fixed number of them into one wide word. It then presents that word through a second valid/ready handshake. A word moves across either port only in a cycle where both valid and ready are high.

The first word of each group lands in the most significant slice of the wide word. Each later word fills the next lower slice. The block has no packet framing. The incoming last flag is accepted and has no effect, and the outgoing last flag is always low. The active level of the synchronous reset is chosen by a parameter. Reset drops any group that is only partly filled.

Top module: `stream_packer`

## Requirements
- R1: The input word is `WORD_W` bits wide. The output word is `WORD_W*LANES` bits wide.
- R2: Within a group, the k-th accepted word (k = 0 first) is placed in bits `[(LANES-k)*WORD_W-1 : (LANES-1-k)*WORD_W]` of `out_array`. The first word therefore goes to the top slice and the last word to the bottom slice.
- R3: `out_valid` rises in the cycle after the `LANES`-th accepted input word of a group, and not earlier.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_array` does not change.
- R5: While a complete word waits with `out_ready` low, `in_ready` is low, so no input word is accepted or lost.
- R6: Whenever `out_ready` is high, `in_ready` is high. A wide word can leave in the same cycle that a new input word enters, and the new word becomes slice 0 of the next group with no idle cycle in between.
- R7: `in_last` has no effect on any output, and `out_last` is always 0.
- R8: Reset clears the slot position and `out_valid`. A partly filled group is discarded, so the first word accepted after reset is slot 0 of a new group. During reset, `out_valid` is 0 and `in_ready` is 1.
- R9: With `RST_ACTIVE_HIGH` = 1 the block resets while `rst` is 1. With `RST_ACTIVE_HIGH` = 0 it resets while `rst` is 0, and otherwise behaves the same.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, level set by `RST_ACTIVE_HIGH` |
| in_data | input | WORD_W | Narrow input word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_last | input | 1 | Input last flag, ignored |
| out_array | output | WORD_W*LANES | Packed wide word, first word in the top slice |
| out_valid | output | 1 | Wide word valid |
| out_ready | input | 1 | Consumer accepts the wide word |
| out_last | output | 1 | Output last flag, always 0 |

## Verification
The assertions assume that the consumer obeys the handshake and that `in_data` is meaningful only in cycles where `in_valid` is high. They place no demand on the producer to hold `in_valid` or `in_data` steady while `in_ready` is low, because the block never relies on that.

The bench drives each input once per cycle on the falling edge. It covers several traffic patterns:
- full-rate flow
- long output stalls
- random valid and ready patterns
- a reset in the middle of a group

It also toggles `in_last` at random, so the ignored flag is exercised throughout.

// File: rtl/packer_pkg.sv
package packer_pkg;
  // Bit offset of the least significant bit of slot `idx`; slot 0 is the top slice.
  function automatic int unsigned slot_lsb(input int unsigned idx,
                                           input int unsigned lanes,
                                           input int unsigned word_w);
    return (lanes - 1 - idx) * word_w;
  endfunction
endpackage

// File: rtl/packer_rst_level.sv
module packer_rst_level #(
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic rst_in,
  output logic rst_act
);
  generate
    if (ACTIVE_HIGH) begin : g_high
      assign rst_act = rst_in;
    end else begin : g_low
      assign rst_act = ~rst_in;
    end
  endgenerate
endmodule

// File: rtl/packer_slot_ctr.sv
module packer_slot_ctr #(
  parameter int unsigned LANES = 4,
  localparam int unsigned CW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic          clk,
  input  logic          rst_act,
  input  logic          step,
  output logic [CW-1:0] idx,
  output logic          at_last
);
  localparam logic [CW-1:0] LAST = CW'(LANES - 1);

  assign at_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst_act) begin
      idx <= '0;
    end else if (step) begin
      idx <= at_last ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/packer_lanes.sv
module packer_lanes
  import packer_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned CW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned TW = WORD_W * LANES
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [TW-1:0]     word_q
);
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int unsigned LSB = slot_lsb(i, LANES, WORD_W);
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == CW'(i))) begin
          word_q[LSB +: WORD_W] <= wr_data;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/stream_packer.sv
module stream_packer #(
  parameter int unsigned WORD_W          = 8,
  parameter int unsigned LANES           = 4,
  parameter bit          RST_ACTIVE_HIGH = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [WORD_W-1:0]         in_data,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_last,
  output logic [WORD_W*LANES-1:0]   out_array,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_last
);
  localparam int unsigned CW = (LANES > 1) ? $clog2(LANES) : 1;

  logic          rst_act;
  logic          take_in;
  logic          take_out;
  logic          slot_last;
  logic [CW-1:0] slot_idx;
  logic          unused_tlast_sink;

  assign unused_tlast_sink = in_last;

  packer_rst_level #(.ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_rst (
    .rst_in (rst),
    .rst_act(rst_act)
  );

  // Room exists when no word is held, or when the held word leaves this cycle.
  assign in_ready = ~out_valid | out_ready;
  assign take_in  = in_valid & in_ready;
  assign take_out = out_valid & out_ready;

  packer_slot_ctr #(.LANES(LANES)) u_ctr (
    .clk    (clk),
    .rst_act(rst_act),
    .step   (take_in),
    .idx    (slot_idx),
    .at_last(slot_last)
  );

  packer_lanes #(.WORD_W(WORD_W), .LANES(LANES)) u_lanes (
    .clk    (clk),
    .wr_en  (take_in),
    .wr_idx (slot_idx),
    .wr_data(in_data),
    .word_q (out_array)
  );

  always_ff @(posedge clk) begin
    if (rst_act) begin
      out_valid <= 1'b0;
    end else if (take_in && slot_last) begin
      out_valid <= 1'b1;
    end else if (take_out) begin
      out_valid <= 1'b0;
    end
  end

  assign out_last = 1'b0;
endmodule

// File: rtl/packer_checker.sv
module packer_checker #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned LANES  = 4,
  localparam int unsigned TW = WORD_W * LANES
) (
  input logic              clk,
  input logic              rst_act,
  input logic [WORD_W-1:0] in_data,
  input logic              in_valid,
  input logic              in_ready,
  input logic [TW-1:0]     out_array,
  input logic              out_valid,
  input logic              out_ready
);
  int unsigned      cnt;
  int unsigned      prev_idx;
  logic             prev_acc;
  logic [WORD_W-1:0] prev_data;
  logic             rst_q;
  logic             acc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    rst_q <= rst_act;
    if (rst_act) begin
      cnt      <= 0;
      prev_acc <= 1'b0;
    end else begin
      prev_acc  <= acc;
      prev_idx  <= cnt;
      prev_data <= in_data;
      if (acc) cnt <= (cnt == LANES - 1) ? 0 : cnt + 1;
    end
  end

  // R2
  always_ff @(posedge clk) begin
    if (!rst_act && !rst_q && prev_acc)
      slot_place_chk: assert (out_array[(LANES-1-prev_idx)*WORD_W +: WORD_W] == prev_data);
  end

  // R8
  always_ff @(posedge clk) begin
    if (rst_q && !rst_act)
      reset_clear_chk: assert (!out_valid);
  end

  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (rst_act)
    (acc && cnt == LANES - 1) |=> out_valid);

  // R3
  no_early_chk: assert property (@(posedge clk) disable iff (rst_act)
    (!out_valid && !(acc && cnt == LANES - 1)) |=> !out_valid);

  // R4
  hold_word_chk: assert property (@(posedge clk) disable iff (rst_act)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_array)));

  // R5
  stall_input_chk: assert property (@(posedge clk) disable iff (rst_act)
    (out_valid && !out_ready) |-> !in_ready);

  // R6
  drain_fill_chk: assert property (@(posedge clk) disable iff (rst_act)
    out_ready |-> in_ready);
endmodule

bind stream_packer packer_checker #(.WORD_W(WORD_W), .LANES(LANES)) u_packer_chk (
  .clk      (clk),
  .rst_act  (rst_act),
  .in_data  (in_data),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_array(out_array),
  .out_valid(out_valid),
  .out_ready(out_ready)
);

// File: tb/stream_packer_bench.sv
`timescale 1ns/1ps
module stream_packer_bench;
  localparam int W = 8;
  localparam int L = 4;
  localparam int T = W * L;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_n;
  logic [W-1:0] in_data = '0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_last;
  logic [T-1:0] out_array;
  logic in_ready_b, out_valid_b, out_last_b;
  logic [T-1:0] out_array_b;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign rst_n = ~rst;

  stream_packer #(.WORD_W(W), .LANES(L), .RST_ACTIVE_HIGH(1'b1)) u_stream_packer (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .out_array(out_array), .out_valid(out_valid),
    .out_ready(out_ready), .out_last(out_last));

  stream_packer #(.WORD_W(W), .LANES(L), .RST_ACTIVE_HIGH(1'b0)) u_stream_packer_lo (
    .clk(clk), .rst(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready_b),
    .in_last(in_last), .out_array(out_array_b), .out_valid(out_valid_b),
    .out_ready(out_ready), .out_last(out_last_b));

  // Behavioural reference
  int fill;
  logic [T-1:0] acc_word, ref_word;
  logic ref_valid;
  logic ref_rdy;

  always @(posedge clk) begin
    if (rst) begin
      fill = 0;
      ref_valid = 1'b0;
    end else begin
      ref_rdy = !ref_valid || out_ready;
      if (ref_valid && out_ready) ref_valid = 1'b0;
      if (in_valid && ref_rdy) begin
        acc_word[(L-1-fill)*W +: W] = in_data;
        fill++;
        if (fill == L) begin
          ref_word = acc_word;
          ref_valid = 1'b1;
          fill = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [T-1:0] act, input logic [T-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid === ref_valid, "R3", T'(out_valid), T'(ref_valid));
    chk(in_ready === (!ref_valid || out_ready), "R5 R6", T'(in_ready), T'(!ref_valid || out_ready));
    if (ref_valid) chk(out_array === ref_word, "R2,R4", out_array, ref_word);
    chk(out_last === 1'b0, "R7", T'(out_last), '0);
    chk({in_ready_b, out_valid_b, out_last_b} === {in_ready, out_valid, out_last},
        "R9", T'({in_ready_b, out_valid_b, out_last_b}), T'({in_ready, out_valid, out_last}));
    if (out_valid) chk(out_array_b === out_array, "R9", out_array_b, out_array);
  endtask

  task automatic step(input bit v, input bit r);
    @(negedge clk);
    cyc++;
    compare();
    in_valid  = v;
    out_ready = r;
    in_data   = W'($urandom);
    in_last   = 1'($urandom);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1: port widths
    chk($bits(out_array) == T && $bits(in_data) == W, "R1", T'($bits(out_array)), T'(T));
    repeat (3) step(1, 0);
    // R8: reset state
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R8", T'({out_valid, in_ready}), T'(2'b01));
    rst = 1'b0;
    // R6: full rate flow, no bubble
    repeat (40) step(1, 1);
    // R4, R5: long stall
    repeat (30) step(1, 0);
    repeat (10) step(0, 1);
    // R8: reset in mid-group discards partial words
    step(1, 1);
    step(1, 1);
    @(negedge clk);
    cyc++;
    compare();
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    cyc++;
    chk(out_valid === 1'b0, "R8", T'(out_valid), '0);
    rst = 1'b0;
    repeat (12) step(1, 1);
    // Random traffic, R7 via random in_last
    for (int i = 0; i < 600; i++) step(1'($urandom), 1'($urandom));
    for (int i = 0; i < 300; i++) step(($urandom % 4) != 0, ($urandom % 5) == 0);
    repeat (8) step(0, 1);
    summary();
  end
endmodule